// File: doc/BRIEF.md
# Soft-Start Reference Ramp Sequencer

This block produces the digital reference code that a voltage regulator follows while it powers up. One LSB of the code is 6.25 mV. Once the block is enabled and power-on-reset is good, it raises the code by one LSB on every soft-start step, up to an intermediate plateau of 176 LSB (1.1 V). It then waits for a voltage-ID target to qualify and ramps on to that target at the same step rate. After the code settles on the target, a fixed delay runs out before the ready flag is raised.

The step interval comes from a run-time input in clock cycles. It stands in for an externally trimmed soft-start oscillator. The ID input is a level qualified by a valid flag. It has no back-pressure: the block watches the code and never stalls the source. Losing enable, losing power-on-reset, or seeing the off-code on a valid ID returns the block to idle in the same cycle.

Top module: `ss_ramp_seq`

## Requirements
- R1: While reset is asserted, or whenever `enable` or `por_good` is low, `ref_code` reads 0, `phase` reads 0 (idle) and `pwr_ready` reads 0. This takes effect in the same cycle as the cause. After the cause clears, the sequence restarts from zero.
- R2: In the two ramp phases, `ref_code` rises by exactly one LSB every `step_period` clock cycles. A `step_period` of 0 behaves as 1.
- R3: If no target has been accepted, the first ramp stops at code 176 and `phase` moves to 2 (wait-ID). The code holds there.
- R4: An ID is accepted as the target only after `vid_valid` has stayed high with an unchanged, non-off `vid_code` for QUAL_CYCLES consecutive cycles (default 25, which is 500 ns at 50 MHz). A change of code restarts the count. Once a target is accepted, later ID changes are ignored until the next restart.
- R5: When a target is accepted in wait-ID, `phase` becomes 3 (ramp2) and the code climbs to the target at the R2 rate.
- R6: If the accepted target is below the code already reached, or below 176, the code stops at the target and never exceeds it.
- R7: When the code reaches the target, `phase` becomes 4 (delay). Exactly READY_CYCLES cycles later (default 4250, which is 85 us at 50 MHz), `phase` becomes 5 (done) and `pwr_ready` goes high.
- R8: A valid ID carrying the off-code (`vid_code` = 0 with `vid_valid` high) acts as a disable, with the outputs of R1.
- R9: `phase` encodes 0 idle, 1 ramp1, 2 wait-ID, 3 ramp2, 4 delay, 5 done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable |
| por_good | input | 1 | Power-on-reset good |
| vid_code | input | CODE_W | Requested target code, in 6.25 mV LSBs |
| vid_valid | input | 1 | Qualifies `vid_code` |
| step_period | input | TICK_W | Clock cycles per ramp step |
| ref_code | output | CODE_W | Reference code |
| phase | output | 3 | Sequencer phase |
| pwr_ready | output | 1 | Ready flag |

## Verification
The bench restarts the ID qualification partway through with a changed code. A design that accepted early would leave wait-ID about ten cycles too soon. It also offers a target below the code the ramp has already reached. A design that compared for equality only would climb past the target and never leave the ramp. The bench drops enable, power-on-reset and the off-code in the middle of a phase and checks the outputs in that same cycle, which catches a design that clears them one register late. It also measures the delay phase to the exact cycle and applies a second ID after acceptance, which exposes an off-by-one counter or a target that is still open to change.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RAMP1 = 3'd1,
    PH_WAIT  = 3'd2,
    PH_RAMP2 = 3'd3,
    PH_DELAY = 3'd4,
    PH_DONE  = 3'd5
  } ss_phase_e;
endpackage

// File: rtl/ss_step_timer.sv
module ss_step_timer #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic [TICK_W-1:0] period,
  output logic              tick
);
  logic [TICK_W-1:0] cnt_q;
  logic [TICK_W-1:0] last;

  // A period of zero behaves as one cycle per step.
  assign last = (period == '0) ? '0 : period - 1'b1;
  assign tick = active && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr || !active)  cnt_q <= '0;
    else if (cnt_q >= last)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  // R2: a live counter never runs past the programmed interval
  p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !clr && $stable(period) && $past(active)) |-> (cnt_q <= last));
endmodule

// File: rtl/ss_id_qualifier.sv
module ss_id_qualifier #(
  parameter int          CODE_W      = 8,
  parameter int          QUAL_CYCLES = 25,
  parameter logic [7:0]  OFF_CODE    = 8'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CODE_W-1:0] id_code,
  input  logic              id_valid,
  output logic              locked,
  output logic [CODE_W-1:0] target
);
  localparam int QW = $clog2(QUAL_CYCLES + 1);
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYCLES - 1);

  logic [QW-1:0]     qcnt_q;
  logic [CODE_W-1:0] hold_q;
  logic              usable;

  assign usable = id_valid && (id_code != CODE_W'(OFF_CODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt_q <= '0;
      hold_q <= '0;
      locked <= 1'b0;
      target <= '0;
    end else if (clr) begin
      qcnt_q <= '0;
      hold_q <= '0;
      locked <= 1'b0;
      target <= '0;
    end else if (!locked) begin
      if (!usable || id_code != hold_q) begin
        hold_q <= id_code;
        qcnt_q <= usable ? QW'(1) : '0;
      end else begin
        qcnt_q <= qcnt_q + 1'b1;
        if (qcnt_q == QLAST) begin
          locked <= 1'b1;
          target <= id_code;
        end
      end
    end
  end

  // R4: an accepted target stays fixed until the next restart
  p_target_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locked) && locked) |-> $stable(target));
  // R4: the off-code is never accepted as a target
  p_no_off_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (target != CODE_W'(OFF_CODE)));
endmodule

// File: rtl/ss_ready_timer.sv
module ss_ready_timer #(
  parameter int READY_CYCLES = 4250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic active,
  output logic expired
);
  localparam int DW = $clog2(READY_CYCLES + 1);
  localparam logic [DW-1:0] DLAST = DW'(READY_CYCLES - 1);

  logic [DW-1:0] cnt_q;

  assign expired = active && (cnt_q == DLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr || !active) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R7: the count never passes the last delay cycle
  p_delay_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q <= DLAST));
endmodule

// File: rtl/ss_ramp_seq.sv
module ss_ramp_seq
  import ss_seq_pkg::*;
#(
  parameter int         CODE_W       = 8,
  parameter int         TICK_W       = 16,
  parameter int         MID_CODE     = 176,
  parameter int         QUAL_CYCLES  = 25,
  parameter int         READY_CYCLES = 4250,
  parameter logic [7:0] OFF_CODE     = 8'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              por_good,
  input  logic [CODE_W-1:0] vid_code,
  input  logic              vid_valid,
  input  logic [TICK_W-1:0] step_period,
  output logic [CODE_W-1:0] ref_code,
  output logic [2:0]        phase,
  output logic              pwr_ready
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(MID_CODE);

  ss_phase_e         phase_q, phase_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              run, clr, tick, locked, expired, ramping;
  logic [CODE_W-1:0] target;

  assign run     = enable && por_good && !(vid_valid && vid_code == CODE_W'(OFF_CODE));
  assign clr     = !run;
  assign ramping = (phase_q == PH_RAMP1) || (phase_q == PH_RAMP2);

  ss_step_timer #(.TICK_W(TICK_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .active(ramping),
    .period(step_period), .tick(tick)
  );

  ss_id_qualifier #(.CODE_W(CODE_W), .QUAL_CYCLES(QUAL_CYCLES), .OFF_CODE(OFF_CODE)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr(clr), .id_code(vid_code),
    .id_valid(vid_valid), .locked(locked), .target(target)
  );

  ss_ready_timer #(.READY_CYCLES(READY_CYCLES)) u_ready (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .active(phase_q == PH_DELAY), .expired(expired)
  );

  always_comb begin
    phase_d = phase_q;
    code_d  = code_q;
    unique case (phase_q)
      PH_IDLE: begin
        phase_d = PH_RAMP1;
        code_d  = '0;
      end
      PH_RAMP1: begin
        if (locked && code_q >= target) begin
          phase_d = PH_DELAY;
          code_d  = target;
        end else if (code_q >= MID) begin
          phase_d = PH_WAIT;
        end else if (tick) begin
          code_d = code_q + 1'b1;
        end
      end
      PH_WAIT: begin
        if (locked) phase_d = PH_RAMP2;
      end
      PH_RAMP2: begin
        if (code_q >= target) begin
          phase_d = PH_DELAY;
          code_d  = target;
        end else if (tick) begin
          code_d = code_q + 1'b1;
        end
      end
      PH_DELAY: begin
        if (expired) phase_d = PH_DONE;
      end
      PH_DONE: ;
      default: begin
        phase_d = PH_IDLE;
        code_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      code_q  <= '0;
    end else if (clr) begin
      phase_q <= PH_IDLE;
      code_q  <= '0;
    end else begin
      phase_q <= phase_d;
      code_q  <= code_d;
    end
  end

  assign ref_code  = run ? code_q : '0;
  assign phase     = run ? phase_q : PH_IDLE;
  assign pwr_ready = run && (phase_q == PH_DONE);

  // R2: inside a ramp the code moves by at most one LSB per cycle
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RAMP1 && $past(phase_q) == PH_RAMP1) |->
      (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1));
  // R3: the first ramp never passes the plateau
  p_plateau_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RAMP1 || phase_q == PH_WAIT) |-> (code_q <= MID));
  // R6: once settled the code equals the accepted target
  p_settled_on_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DELAY || phase_q == PH_DONE) |-> (locked && code_q == target));
  // R1: ready only with the block running
  p_ready_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ready |-> (enable && por_good));
endmodule

// File: tb/test_ss_ramp_seq.sv
module test_ss_ramp_seq;
  localparam int RDY = 4250;
  localparam int QC  = 25;
  localparam int MID = 176;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       por_good = 1'b1;
  logic [7:0] vid_code = 8'd0;
  logic       vid_valid = 1'b0;
  logic [15:0] step_period = 16'd2;
  logic [7:0] ref_code;
  logic [2:0] phase;
  logic       pwr_ready;

  int checks = 0, fails = 0, cycles = 0;
  bit started = 1'b0;

  ss_ramp_seq i_ss_ramp_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .por_good(por_good),
    .vid_code(vid_code), .vid_valid(vid_valid), .step_period(step_period),
    .ref_code(ref_code), .phase(phase), .pwr_ready(pwr_ready)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_ph, m_code, m_tcnt, m_qcnt, m_hold, m_lock, m_tgt, m_dcnt;

  function automatic bit m_run();
    return enable && por_good && !(vid_valid && vid_code == 8'd0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !m_run()) begin
      m_ph = 0; m_code = 0; m_tcnt = 0; m_qcnt = 0; m_hold = 0;
      m_lock = 0; m_tgt = 0; m_dcnt = 0;
    end else begin
      int ph, code, lock, tgt, pm1;
      bit tk, ramp, fin;
      ph = m_ph; code = m_code; lock = m_lock; tgt = m_tgt;
      pm1 = (step_period == 0) ? 0 : int'(step_period) - 1;
      ramp = (ph == 1 || ph == 3);
      tk = ramp && (m_tcnt >= pm1);
      fin = (ph == 4) && (m_dcnt == RDY - 1);
      if (ramp) m_tcnt = (m_tcnt >= pm1) ? 0 : m_tcnt + 1; else m_tcnt = 0;
      if (ph == 4) m_dcnt++; else m_dcnt = 0;
      if (!m_lock) begin
        if (!vid_valid || int'(vid_code) != m_hold) begin
          m_hold = vid_code; m_qcnt = vid_valid ? 1 : 0;
        end else begin
          if (m_qcnt == QC - 1) begin m_lock = 1; m_tgt = vid_code; end
          m_qcnt++;
        end
      end
      case (ph)
        0: begin m_ph = 1; m_code = 0; end
        1: if (lock && code >= tgt) begin m_ph = 4; m_code = tgt; end
           else if (code >= MID) m_ph = 2;
           else if (tk) m_code = code + 1;
        2: if (lock) m_ph = 3;
        3: if (code >= tgt) begin m_ph = 4; m_code = tgt; end
           else if (tk) m_code = code + 1;
        4: if (fin) m_ph = 5;
        default: ;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (started) begin
    bit r;
    r = m_run() && rst_n;
    chk(ref_code == (r ? m_code : 0), "R2 ref_code vs model", ref_code, r ? m_code : 0);
    chk(phase == (r ? m_ph : 0), "R9 phase vs model", phase, r ? m_ph : 0);
    chk(pwr_ready == (r && m_ph == 5), "R7 ready vs model", pwr_ready, r && m_ph == 5);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_phase(int p, int maxc, string tag);
    for (int i = 0; i < maxc; i++) begin
      if (phase == 3'(p)) return;
      cyc(1);
    end
    chk(0, tag, phase, p);
  endtask

  initial begin
    cyc(3);
    started = 1'b1;
    #1;
    chk(ref_code == 0 && phase == 0 && !pwr_ready, "R1 reset state", ref_code, 0);
    rst_n = 1'b1;
    cyc(1);
    // first ramp to plateau, no target
    enable = 1'b1;
    wait_phase(2, 2000, "R3 reach wait-ID");
    chk(ref_code == 8'(MID), "R3 plateau code", ref_code, MID);
    cyc(20);
    chk(phase == 2 && ref_code == 8'(MID), "R3 holds at plateau", phase, 2);
    // qualification restarted by a code change
    vid_code = 8'd200; vid_valid = 1'b1;
    cyc(10);
    vid_code = 8'd201;
    cyc(20);
    chk(phase == 2, "R4 no early accept", phase, 2);
    cyc(10);
    chk(phase == 3, "R5 ramp2 after accept", phase, 3);
    wait_phase(4, 1000, "R5 reach delay");
    chk(ref_code == 8'd201, "R5 ramp2 target", ref_code, 201);
    begin
      int n = 0;
      while (phase != 3'd5 && n < RDY + 10) begin cyc(1); n++; end
      chk(n == RDY, "R7 delay length", n, RDY);
    end
    chk(pwr_ready == 1'b1, "R7 ready high", pwr_ready, 1);
    // later ID ignored
    vid_code = 8'd220;
    cyc(40);
    chk(ref_code == 8'd201 && pwr_ready, "R4 later ID ignored", ref_code, 201);
    // off-code acts as disable in the same cycle
    vid_code = 8'd0;
    #1;
    chk(ref_code == 0 && phase == 0 && !pwr_ready, "R8 off-code clears", ref_code, 0);
    cyc(2);
    // restart with low target and zero period
    vid_valid = 1'b0; vid_code = 8'd100; step_period = 16'd0;
    cyc(1);
    vid_valid = 1'b1;
    wait_phase(4, 1000, "R6 settle on low target");
    chk(ref_code == 8'd100, "R6 stops at low target", ref_code, 100);
    wait_phase(5, RDY + 20, "R7 done after low target");
    chk(ref_code == 8'd100 && pwr_ready, "R6 no overshoot at done", ref_code, 100);
    // disable mid-ramp
    enable = 1'b0; vid_valid = 1'b0;
    cyc(2);
    enable = 1'b1; step_period = 16'd3;
    cyc(60);
    chk(phase == 1 && ref_code > 0, "R2 ramping with period 3", ref_code, 19);
    enable = 1'b0;
    #1;
    chk(ref_code == 0 && phase == 0, "R1 disable same cycle", ref_code, 0);
    cyc(2);
    enable = 1'b1;
    cyc(30);
    por_good = 1'b0;
    #1;
    chk(ref_code == 0 && phase == 0 && !pwr_ready, "R1 POR loss same cycle", ref_code, 0);
    cyc(2);
    por_good = 1'b1;
    // target accepted after the ramp passed it
    step_period = 16'd1;
    cyc(150);
    vid_code = 8'd120; vid_valid = 1'b1;
    cyc(30);
    chk(phase >= 4 && ref_code == 8'd120, "R6 late low target", ref_code, 120);
    cyc(5);
    started = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule